// File: doc/BRIEF.md
# Time-of-Arrival Pixel Digital Back-End

This block is the digital half of one pixel in a single-photon imaging array. A 10-bit time-stamp counter runs on a fast clock from the start of each frame. The first rising edge of the comparator output in that frame freezes a copy of the count, which records when the photon arrived. If no photon arrives, the stored value stays at all ones. The comparator output is asynchronous, so it crosses into the time-stamp domain through a synchronizer.

A per-pixel serial chain carries the captured stamps to the array edge. A load strobe, taken on the readout clock, copies the stored stamp into a 10-bit shift register. The next frame then starts in the time-stamp domain, and the previous value is shifted out while the new frame acquires. The pixel therefore has no dead time between frames.

A second serial chain, on a slow configuration clock, carries an 11-bit word into a shadow register. An update strobe moves the shadow word to the active outputs. The active outputs are an 8-bit offset-trim code for the comparator DAC and three mode bits. Mode bit 0 switches the pixel off, so hits are ignored. The three clocks (time stamp, readout, configuration) are independent. One active-low reset clears all three domains.

Top module: `toa_pixel_backend`

## Requirements
- R1: After a load, the frame starts at the third time-stamp clock edge following the readout edge that sampled the load. The count is 0 at that edge and rises by one per time-stamp edge. When hitIn rises just after time-stamp edge N, the capture happens at edge N+3. The stored value is the count held just before that edge.
- R2: Only the first rising edge of hitIn in a frame is captured. A later edge in the same frame, or a level held high from the previous frame, leaves the stored value unchanged.
- R3: If a frame ends with no capture, the value loaded for readout is 1023 (all ones). The counter saturates at 1023, so a hit that comes after 1023 counts also reads 1023.
- R4: While active mode bit 0 is 1, hits are ignored and the frame reads 1023. Clearing the bit with a new configuration enables capture again.
- R5: While cfgShift is high, each cfgClk edge shifts cfgSerIn into the shadow word, least significant bit first. After 11 shifts, a cfgUpdate edge makes trimCode equal word bits 7:0 and modeOut equal word bits 10:8.
- R6: trimCode and modeOut change only on a cfgClk edge where cfgUpdate is high. They hold their value while the word is being shifted.
- R7: cfgSerOut shows shadow bit 0. The bits of the previously shifted word leave in order, least significant first, while the next word shifts in.
- R8: On a roClk edge with roLoad high, the shift register takes the stored stamp, and roSerOut shows bit 9 at once. Each later roClk edge without roLoad moves the next lower bit to roSerOut, so the stamp leaves most significant bit first.
- R9: roSerIn enters at bit 0 on every roClk edge without roLoad. A bit taken at edge k shows on roSerOut after edge k+9.
- R10: A hit in the frame that starts with a load is captured correctly while the previous stamp is still shifting out.
- R11: While reset is applied: trimCode, modeOut, cfgSerOut and roSerOut are 0, the counter is 0, and the stored stamp is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tsClk | input | 1 | Fast time-stamp clock |
| roClk | input | 1 | Readout shift clock |
| cfgClk | input | 1 | Configuration clock |
| rstN | input | 1 | Asynchronous active-low reset, all domains |
| hitIn | input | 1 | Asynchronous comparator output |
| cfgShift | input | 1 | Shift enable for the configuration chain |
| cfgUpdate | input | 1 | Copies the shadow word to the active outputs |
| cfgSerIn | input | 1 | Configuration serial input |
| cfgSerOut | output | 1 | Configuration serial output to the next pixel |
| trimCode | output | 8 | Active comparator-offset trim code |
| modeOut | output | 3 | Active mode bits; bit 0 switches the pixel off |
| roLoad | input | 1 | Parallel load of the stored stamp; starts a new frame |
| roSerIn | input | 1 | Readout serial input from the neighbouring pixel |
| roSerOut | output | 1 | Readout serial output |

## Verification
Capture is tried with five frame types: a frame with no hit, a hit early in a frame followed by a second edge in the same frame, a hit placed during the shift-out of the previous stamp, a hit after counter saturation, and a hit while the off bit is set. Telling the expected offset apart from the empty value 1023 shows that the synchronizer latency and frame start are counted correctly, that the first edge wins, and that the disable gate works. Frames whose readout overlaps the next acquisition separate correct dead-time-free behaviour from a design that clears or overwrites the stamp too early. The serial chains are driven with asymmetric bit patterns, so a reversed order or an off-by-one shift is visible.

// File: rtl/toa_pkg.sv
`timescale 1ns/1ps
package toa_pkg;
  // Strobes from the time-stamp control to the datapath (tsClk domain)
  typedef struct packed {
    logic frameClear;  // start a new frame: zero the counter, empty the capture
    logic capture;     // freeze the current count as time of arrival
  } tsStrobe_t;
endpackage

// File: rtl/toa_sync.sv
`timescale 1ns/1ps
module toa_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic stage;
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage <= 1'b0;
        else       stage <= d;
      assign q = stage;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/toa_cfg_reg.sv
`timescale 1ns/1ps
module toa_cfg_reg #(
  parameter int TRIM_W = 8,
  parameter int MODE_W = 3
) (
  input  logic              cfgClk,
  input  logic              rstN,
  input  logic              cfgShift,
  input  logic              cfgUpdate,
  input  logic              cfgSerIn,
  output logic              cfgSerOut,
  output logic [TRIM_W-1:0] trimCode,
  output logic [MODE_W-1:0] modeBits
);
  localparam int CFG_W = TRIM_W + MODE_W;

  logic [CFG_W-1:0] shadow;
  logic [CFG_W-1:0] active;

  // Shift right: the first bit in ends up at bit 0 (LSB first)
  always_ff @(posedge cfgClk or negedge rstN)
    if (!rstN)         shadow <= '0;
    else if (cfgShift) shadow <= {cfgSerIn, shadow[CFG_W-1:1]};

  // Outputs only move on update, so the trim code never sees shifting bits
  always_ff @(posedge cfgClk or negedge rstN)
    if (!rstN)          active <= '0;
    else if (cfgUpdate) active <= shadow;

  assign cfgSerOut = shadow[0];
  assign trimCode  = active[TRIM_W-1:0];
  assign modeBits  = active[CFG_W-1:TRIM_W];
endmodule

// File: rtl/toa_ts_ctrl.sv
`timescale 1ns/1ps
module toa_ts_ctrl
  import toa_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      tsClk,
  input  logic      rstN,
  input  logic      hitIn,
  input  logic      loadFlag,
  input  logic      pixelOff,
  input  logic      hitSeen,
  output tsStrobe_t strobe
);
  logic hitSync, hitPrev;
  logic loadSync, loadPrev;

  toa_sync #(.STAGES(SYNC_STAGES)) uHitSync (
    .clk(tsClk), .rstN(rstN), .d(hitIn), .q(hitSync)
  );

  toa_sync #(.STAGES(SYNC_STAGES)) uLoadSync (
    .clk(tsClk), .rstN(rstN), .d(loadFlag), .q(loadSync)
  );

  always_ff @(posedge tsClk or negedge rstN)
    if (!rstN) begin
      hitPrev  <= 1'b0;
      loadPrev <= 1'b0;
    end else begin
      hitPrev  <= hitSync;
      loadPrev <= loadSync;
    end

  always_comb begin
    strobe.frameClear = loadSync & ~loadPrev;
    strobe.capture    = hitSync & ~hitPrev & ~hitSeen & ~pixelOff & ~strobe.frameClear;
  end
endmodule

// File: rtl/toa_datapath.sv
`timescale 1ns/1ps
module toa_datapath
  import toa_pkg::*;
#(
  parameter int TS_W = 10
) (
  input  logic            tsClk,
  input  logic            roClk,
  input  logic            rstN,
  input  tsStrobe_t       strobe,
  input  logic            roLoad,
  input  logic            roSerIn,
  output logic            roSerOut,
  output logic            loadFlag,
  output logic            hitSeen,
  output logic [TS_W-1:0] tsCount,
  output logic [TS_W-1:0] capVal,
  output logic [TS_W-1:0] roWord
);
  localparam logic [TS_W-1:0] CNT_MAX = '1;

  // Time-stamp domain: saturating counter and capture register
  always_ff @(posedge tsClk or negedge rstN)
    if (!rstN)                  tsCount <= '0;
    else if (strobe.frameClear) tsCount <= '0;
    else if (tsCount != CNT_MAX) tsCount <= tsCount + 1'b1;

  always_ff @(posedge tsClk or negedge rstN)
    if (!rstN) begin
      capVal  <= CNT_MAX;
      hitSeen <= 1'b0;
    end else if (strobe.frameClear) begin
      capVal  <= CNT_MAX;
      hitSeen <= 1'b0;
    end else if (strobe.capture) begin
      capVal  <= tsCount;
      hitSeen <= 1'b1;
    end

  // Readout domain: the load flag is registered here, so the time-stamp side
  // only starts a new frame after the copy has been taken
  always_ff @(posedge roClk or negedge rstN)
    if (!rstN) begin
      loadFlag <= 1'b0;
      roWord   <= '0;
    end else begin
      loadFlag <= roLoad;
      if (roLoad) roWord <= capVal;
      else        roWord <= {roWord[TS_W-2:0], roSerIn};
    end

  assign roSerOut = roWord[TS_W-1];
endmodule

// File: rtl/toa_pixel_backend.sv
`timescale 1ns/1ps
module toa_pixel_backend
  import toa_pkg::*;
#(
  parameter int TS_W        = 10,
  parameter int TRIM_W      = 8,
  parameter int MODE_W      = 3,
  parameter int DISABLE_BIT = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              tsClk,
  input  logic              roClk,
  input  logic              cfgClk,
  input  logic              rstN,
  input  logic              hitIn,
  input  logic              cfgShift,
  input  logic              cfgUpdate,
  input  logic              cfgSerIn,
  output logic              cfgSerOut,
  output logic [TRIM_W-1:0] trimCode,
  output logic [MODE_W-1:0] modeOut,
  input  logic              roLoad,
  input  logic              roSerIn,
  output logic              roSerOut
);
  tsStrobe_t       strobe;
  logic            loadFlag;
  logic            hitSeen;
  logic            pixelOff;
  logic [TS_W-1:0] tsCount;
  logic [TS_W-1:0] capVal;
  logic [TS_W-1:0] roWord;

  // Mode bits are quasi-static: written only between frames
  assign pixelOff = modeOut[DISABLE_BIT];

  toa_cfg_reg #(.TRIM_W(TRIM_W), .MODE_W(MODE_W)) uCfg (
    .cfgClk(cfgClk), .rstN(rstN), .cfgShift(cfgShift), .cfgUpdate(cfgUpdate),
    .cfgSerIn(cfgSerIn), .cfgSerOut(cfgSerOut), .trimCode(trimCode),
    .modeBits(modeOut)
  );

  toa_ts_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .tsClk(tsClk), .rstN(rstN), .hitIn(hitIn), .loadFlag(loadFlag),
    .pixelOff(pixelOff), .hitSeen(hitSeen), .strobe(strobe)
  );

  toa_datapath #(.TS_W(TS_W)) uPath (
    .tsClk(tsClk), .roClk(roClk), .rstN(rstN), .strobe(strobe),
    .roLoad(roLoad), .roSerIn(roSerIn), .roSerOut(roSerOut),
    .loadFlag(loadFlag), .hitSeen(hitSeen), .tsCount(tsCount),
    .capVal(capVal), .roWord(roWord)
  );
endmodule

// File: rtl/toa_pixel_checker.sv
`timescale 1ns/1ps
module toa_pixel_checker #(
  parameter int TS_W   = 10,
  parameter int TRIM_W = 8,
  parameter int MODE_W = 3
) (
  input logic              tsClk,
  input logic              roClk,
  input logic              cfgClk,
  input logic              rstN,
  input logic              cfgUpdate,
  input logic [TRIM_W-1:0] trimCode,
  input logic [MODE_W-1:0] modeOut,
  input logic              roLoad,
  input logic              roSerOut,
  input logic              pixelOff,
  input logic              hitSeen,
  input logic              frameClear,
  input logic [TS_W-1:0]   tsCount,
  input logic [TS_W-1:0]   capVal,
  input logic [TS_W-1:0]   roWord
);
  // R6: active configuration only moves on an update edge
  a_r6_cfg_hold: assert property (@(posedge cfgClk) disable iff (!rstN)
    !cfgUpdate |=> ($stable(trimCode) && $stable(modeOut)));

  // R2: once a hit is held, only a new frame may change the stored stamp
  a_r2_first_hit_only: assert property (@(posedge tsClk) disable iff (!rstN)
    (capVal != $past(capVal)) |-> ($past(frameClear) || !$past(hitSeen)));

  // R4: with the pixel switched off, only a new frame may change the stamp
  a_r4_off_ignores: assert property (@(posedge tsClk) disable iff (!rstN)
    (capVal != $past(capVal)) |-> ($past(frameClear) || !$past(pixelOff)));

  // R3: the counter stays at full scale until the next frame
  a_r3_saturate: assert property (@(posedge tsClk) disable iff (!rstN)
    ((&tsCount) && !frameClear) |=> (&tsCount));

  // R8: after a load the top stamp bit is on the serial output
  a_r8_load_msb: assert property (@(posedge roClk) disable iff (!rstN)
    roLoad |=> (roSerOut == $past(capVal[TS_W-1])));

  // R9: without a load the next lower bit moves to the serial output
  a_r9_shift_order: assert property (@(posedge roClk) disable iff (!rstN)
    !roLoad |=> (roSerOut == $past(roWord[TS_W-2])));
endmodule

bind toa_pixel_backend toa_pixel_checker #(
  .TS_W(TS_W), .TRIM_W(TRIM_W), .MODE_W(MODE_W)
) uChecker (
  .tsClk(tsClk), .roClk(roClk), .cfgClk(cfgClk), .rstN(rstN),
  .cfgUpdate(cfgUpdate), .trimCode(trimCode), .modeOut(modeOut),
  .roLoad(roLoad), .roSerOut(roSerOut), .pixelOff(pixelOff),
  .hitSeen(hitSeen), .frameClear(strobe.frameClear), .tsCount(tsCount),
  .capVal(capVal), .roWord(roWord)
);

// File: tb/toa_pixel_backend_test.sv
`timescale 1ns/1ps
module toa_pixel_backend_test;
  logic tsClk = 1'b0, roClk = 1'b0, cfgClk = 1'b0;
  logic rstN = 1'b0, hitIn = 1'b0;
  logic cfgShift = 1'b0, cfgUpdate = 1'b0, cfgSerIn = 1'b0;
  logic roLoad = 1'b0, roSerIn = 1'b0;
  logic cfgSerOut, roSerOut;
  logic [7:0] trimCode;
  logic [2:0] modeOut;

  toa_pixel_backend uut (
    .tsClk(tsClk), .roClk(roClk), .cfgClk(cfgClk), .rstN(rstN), .hitIn(hitIn),
    .cfgShift(cfgShift), .cfgUpdate(cfgUpdate), .cfgSerIn(cfgSerIn),
    .cfgSerOut(cfgSerOut), .trimCode(trimCode), .modeOut(modeOut),
    .roLoad(roLoad), .roSerIn(roSerIn), .roSerOut(roSerOut)
  );

  always #2.5 tsClk  = ~tsClk;   // 200 MHz time-stamp clock
  always #8   roClk  = ~roClk;
  always #50  cfgClk = ~cfgClk;

  int tsEdges = 0;               // bench's own edge count
  always @(posedge tsClk) tsEdges <= tsEdges + 1;

  int testsRun = 0, testsFailed = 0;
  bit finished = 1'b0;
  int lastM = 0;
  int pending = 1023;
  logic [10:0] prevCfg = '0;
  logic [9:0] expQ[$];
  string tagQ[$];
  logic [9:0] got;
  logic [9:0] expWord;
  string expTag;

  task automatic check(input string req, input int act, input int exp, input string what);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int x);
    return (x > 1023) ? 1023 : x;
  endfunction

  // Configuration write: checks the chain output and the hold of the outputs
  task automatic cfgWrite(input logic [10:0] word);
    for (int i = 0; i < 11; i++) begin
      check("R7", cfgSerOut, prevCfg[i], "config chain bit out");
      cfgSerIn = word[i];
      cfgShift = 1'b1;
      @(posedge cfgClk); #0.2;
      if (i == 5) check("R6", trimCode, prevCfg[7:0], "trim during shift");
    end
    cfgShift = 1'b0;
    check("R6", modeOut, prevCfg[10:8], "mode before update");
    cfgUpdate = 1'b1;
    @(posedge cfgClk); #0.2;
    cfgUpdate = 1'b0;
    check("R5", trimCode, word[7:0], "trim after update");
    check("R5", modeOut, word[10:8], "mode after update");
    prevCfg = word;
  endtask

  // Driver: pushes the expected stamp of the ending frame, then pulses the load
  task automatic loadFrame(input string tag);
    expQ.push_back(pending[9:0]);
    tagQ.push_back(tag);
    @(posedge roClk); #0.2;
    roLoad = 1'b1;
    @(posedge roClk); #0.2;
    lastM  = tsEdges;
    roLoad = 1'b0;
    pending = 1023;
  endtask

  task automatic hitAfter(input int waitCycles, input bit counts);
    int n;
    repeat (waitCycles) @(posedge tsClk);
    #0.2;
    n = tsEdges;
    hitIn = 1'b1;
    if (counts) pending = sat(n - lastM - 1);
    repeat (4) @(posedge tsClk);
    #0.2;
    hitIn = 1'b0;
  endtask

  // Monitor: collects ten bits after each load and compares with the queue
  initial begin
    forever begin
      @(posedge roClk);
      if (roLoad) begin
        #0.2 got[9] = roSerOut;
        for (int b = 8; b >= 0; b--) begin
          @(posedge roClk); #0.2;
          got[b] = roSerOut;
        end
        if (expQ.size() == 0) begin
          check("R8", 1, 0, "unexpected readout word");
        end else begin
          expWord = expQ.pop_front();
          expTag  = tagQ.pop_front();
          check({expTag, " R8"}, got, expWord, "serial stamp");
        end
      end
    end
  end

  initial begin
    logic [9:0] pat;
    pat = 10'b1011001110;
    #203;
    // R11: reset values
    check("R11", trimCode, 0, "trim in reset");
    check("R11", modeOut, 0, "mode in reset");
    check("R11", cfgSerOut, 0, "config out in reset");
    check("R11", roSerOut, 0, "readout out in reset");
    rstN = 1'b1;
    #1;

    cfgWrite({3'b010, 8'hA5});
    loadFrame("R3 R11");            // first frame: no hit, empty stamp

    hitAfter(40, 1'b1);             // first edge counts
    hitAfter(30, 1'b0);             // second edge in same frame ignored
    loadFrame("R1 R2");

    hitAfter(20, 1'b1);             // hit while previous stamp shifts out
    repeat (40) @(posedge tsClk);
    loadFrame("R10");

    hitAfter(1100, 1'b1);           // past saturation
    loadFrame("R3");

    cfgWrite({3'b011, 8'h5A});      // pixel off
    hitAfter(10, 1'b0);
    loadFrame("R4");

    // R9: chain through roSerIn while the previous word leaves
    for (int k = 1; k <= 19; k++) begin
      if (k <= 10) roSerIn = pat[k-1];
      @(posedge roClk); #0.2;
      if (k >= 10) check("R9", roSerOut, pat[k-10], "chained bit");
    end
    roSerIn = 1'b0;

    cfgWrite({3'b110, 8'h3C});      // pixel on again
    hitAfter(15, 1'b1);
    loadFrame("R4 R1");

    repeat (14) @(posedge roClk);
    check("R8", expQ.size(), 0, "words left unread");
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R1 watchdog: got running expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule